// File: doc/BRIEF.md
# Vertical-Crosswise Recursive Unsigned Multiplier

This block multiplies two unsigned operands of equal width and returns the full double-width product, with no clock and no internal state. Its leaf is an 8x8 cell that builds the product one column at a time. Column k gathers every AND of an operand bit pair whose indices add up to k, all of them formed at once before any addition begins. It adds the count handed on by the column below. It keeps the low bit as product bit k and hands the rest upward.

Widths above eight are assembled recursively. Each operand is cut into a high half and a low half, and four half-width multipliers produce the four partial products. The two cross terms are added with their carry preserved. The result is shifted by half the width and added to the concatenation of the high-by-high and low-by-low products. One parameter selects a width of 8, 16, 32 or 64 bits. The block is intended as a single-cycle arithmetic element inside a multiply-accumulate datapath, where the surrounding logic registers its inputs and output.

Top module: `vcm_multiplier`

## Requirements
- R1: For the default width of 64, `product` equals the exact unsigned product of `a` and `b` over all 128 bits. When the upper halves of both operands are zero, the upper half of `product` is zero.
- R2: For each supported value of the width parameter (8, 16, 32 and 64), `product` is the exact unsigned product of the operands, zero-extended to no more than twice the width.
- R3: If either operand is zero, every bit of `product` is zero.
- R4: If one operand equals 1, `product` equals the other operand in its low half and zero in its high half.
- R5: With both operands all ones, `product` equals (2^W-1)^2. This is a single 1 in bit 0, zeros in bits 1 to W-1, a 0 in bit W, and ones in bits W+1 to 2W-1.
- R6: If `a` = 2^i and `b` = 2^j, then `product` has exactly one bit set, at position i+j.
- R7: The block is purely combinational. A change on `a` or `b` is reflected on `product` in the same clock cycle, and back-to-back operand changes on consecutive cycles each give their own correct product.
- R8: No carry is ever produced beyond bit 2W-1. The carries leaving the top columns of each 8x8 cell are zero, and so is the carry out of the final addition at every recursion level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a | input | WIDTH | Unsigned multiplicand |
| b | input | WIDTH | Unsigned multiplier |
| product | output | 2*WIDTH | Unsigned product of a and b |

## Verification
Every result is due in the same cycle as its stimulus, because no register lies between the operands and the product. The bench applies a new operand pair just after each rising edge and records its expectation in a queue. Half a period later, at the falling edge, it takes that entry out and compares it with all four width variants driven from slices of the same operands. A pair therefore never overlaps the next one, and a result is never read while it is still settling.

// File: rtl/vcm_pkg.sv
package vcm_pkg;

    // Width of the leaf column-sum cell.
    localparam int unsigned CELL_W = 8;

    // One-bit full adder result.
    typedef struct packed {
        logic carry;
        logic sum;
    } fa_out_t;

    function automatic fa_out_t full_add(input logic x, input logic y, input logic z);
        fa_out_t r;
        r.sum   = x ^ y ^ z;
        r.carry = (x & y) | (x & z) | (y & z);
        return r;
    endfunction

    // Bits needed to hold one column count (cross products plus carry in).
    function automatic int unsigned col_count_w(input int unsigned w);
        return $clog2(2 * w) + 1;
    endfunction

    // Index range of the first operand taking part in column k.
    function automatic int unsigned col_lo(input int unsigned w, input int unsigned k);
        return (k >= w) ? (k - w + 1) : 0;
    endfunction

    function automatic int unsigned col_hi(input int unsigned w, input int unsigned k);
        return (k < w) ? k : (w - 1);
    endfunction

endpackage

// File: rtl/vcm_ripple_add.sv
module vcm_ripple_add #(
    parameter int unsigned W = 16
) (
    input  logic [W-1:0] x,
    input  logic [W-1:0] y,
    input  logic         cin,
    output logic [W-1:0] sum,
    output logic         cout
);
    import vcm_pkg::*;

    logic [W:0] chain;
    assign chain[0] = cin;

    for (genvar k = 0; k < W; k++) begin : g_bit
        fa_out_t fo;
        assign fo         = full_add(x[k], y[k], chain[k]);
        assign sum[k]     = fo.sum;
        assign chain[k+1] = fo.carry;
    end

    assign cout = chain[W];

endmodule

// File: rtl/vcm_cell.sv
module vcm_cell #(
    parameter int unsigned W = vcm_pkg::CELL_W
) (
    input  logic [W-1:0]   a,
    input  logic [W-1:0]   b,
    output logic [2*W-1:0] p
);
    import vcm_pkg::*;

    localparam int unsigned NCOL = 2 * W - 1;
    localparam int unsigned CW   = col_count_w(W);

    // col_carry[k] is the count handed into column k.
    logic [NCOL:0][CW-1:0] col_carry;
    assign col_carry[0] = '0;

    for (genvar k = 0; k < NCOL; k++) begin : g_col
        localparam int unsigned LO = col_lo(W, k);
        localparam int unsigned HI = col_hi(W, k);

        // All crosswise AND terms of this column, formed in parallel.
        logic [W-1:0] xp;
        for (genvar i = 0; i < W; i++) begin : g_xp
            if (i >= LO && i <= HI) begin : g_on
                assign xp[i] = a[i] & b[k-i];
            end else begin : g_off
                assign xp[i] = 1'b0;
            end
        end

        logic [CW-1:0] total;
        always_comb begin
            total = col_carry[k];
            for (int i = 0; i < W; i++) begin
                total = total + CW'(xp[i]);
            end
        end

        assign p[k]           = total[0];
        assign col_carry[k+1] = total >> 1;
    end

    // Top product bit is the lowest carry bit out of the last column.
    assign p[2*W-1] = col_carry[NCOL][0];

    logic [CW-2:0] dropped;
    assign dropped = col_carry[NCOL][CW-1:1];

    always_comb begin
        // R8: carries above the top column are redundant and always zero.
        a_r8_cell_no_top_carry: assert (dropped == '0)
            else $error("cell carried beyond top bit");
        if (a == '0 || b == '0) begin
            a_r3_cell_zero_operand: assert (p == '0)
                else $error("cell zero operand gave nonzero product");
        end
        if (a == W'(1)) begin
            a_r4_cell_unit_operand: assert (p == {{W{1'b0}}, b})
                else $error("cell unit operand mismatch");
        end
    end

endmodule

// File: rtl/vcm_mult.sv
module vcm_mult #(
    parameter int unsigned W = 16
) (
    input  logic [W-1:0]   a,
    input  logic [W-1:0]   b,
    output logic [2*W-1:0] p
);
    import vcm_pkg::*;

    if (W <= CELL_W) begin : g_leaf
        vcm_cell #(.W(W)) u_cell (
            .a(a),
            .b(b),
            .p(p)
        );
    end else begin : g_split
        localparam int unsigned H = W / 2;

        logic [H-1:0] a_hi, a_lo, b_hi, b_lo;
        assign a_hi = a[W-1:H];
        assign a_lo = a[H-1:0];
        assign b_hi = b[W-1:H];
        assign b_lo = b[H-1:0];

        logic [W-1:0] pp_ll, pp_lh, pp_hl, pp_hh;

        vcm_mult #(.W(H)) u_ll (.a(a_lo), .b(b_lo), .p(pp_ll));
        vcm_mult #(.W(H)) u_lh (.a(a_lo), .b(b_hi), .p(pp_lh));
        vcm_mult #(.W(H)) u_hl (.a(a_hi), .b(b_lo), .p(pp_hl));
        vcm_mult #(.W(H)) u_hh (.a(a_hi), .b(b_hi), .p(pp_hh));

        // Cross terms summed with their carry kept.
        logic [W-1:0] mid_sum;
        logic         mid_c;
        vcm_ripple_add #(.W(W)) u_mid (
            .x   (pp_lh),
            .y   (pp_hl),
            .cin (1'b0),
            .sum (mid_sum),
            .cout(mid_c)
        );

        logic [2*W-1:0] outer;
        logic [2*W-1:0] mid_sh;
        assign outer  = {pp_hh, pp_ll};
        assign mid_sh = {{(H-1){1'b0}}, mid_c, mid_sum, {H{1'b0}}};

        logic fin_c;
        vcm_ripple_add #(.W(2*W)) u_fin (
            .x   (outer),
            .y   (mid_sh),
            .cin (1'b0),
            .sum (p),
            .cout(fin_c)
        );

        always_comb begin
            // R8: combining the partial products never overflows 2W bits.
            a_r8_level_no_final_carry: assert (fin_c == 1'b0)
                else $error("final addition carried out");
            if (a_hi == '0 && b_hi == '0) begin
                a_r1_upper_half_clear: assert (p[2*W-1:W] == '0)
                    else $error("upper half set for small operands");
            end
        end
    end

endmodule

// File: rtl/vcm_multiplier.sv
module vcm_multiplier #(
    parameter int unsigned WIDTH = 64
) (
    input  logic [WIDTH-1:0]   a,
    input  logic [WIDTH-1:0]   b,
    output logic [2*WIDTH-1:0] product
);

    vcm_mult #(.W(WIDTH)) u_core (
        .a(a),
        .b(b),
        .p(product)
    );

    always_comb begin
        if ($onehot(a) && $onehot(b)) begin
            a_r6_single_bit_product: assert ($countones(product) == 1)
                else $error("power-of-two operands gave non-single-bit product");
        end
        if (a == WIDTH'(1)) begin
            a_r4_top_unit_operand: assert (product == {{WIDTH{1'b0}}, b})
                else $error("unit operand mismatch at top");
        end
    end

endmodule

// File: tb/vcm_multiplier_tb.sv
module vcm_multiplier_tb;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2 clk = ~clk;   // 250 MHz

    logic [63:0]  op_a = '0;
    logic [63:0]  op_b = '0;
    logic [127:0] p64;
    logic [63:0]  p32;
    logic [31:0]  p16;
    logic [15:0]  p8;

    vcm_multiplier #(.WIDTH(64)) u_dut   (.a(op_a),        .b(op_b),        .product(p64));
    vcm_multiplier #(.WIDTH(32)) u_dut32 (.a(op_a[31:0]),  .b(op_b[31:0]),  .product(p32));
    vcm_multiplier #(.WIDTH(16)) u_dut16 (.a(op_a[15:0]),  .b(op_b[15:0]),  .product(p16));
    vcm_multiplier #(.WIDTH(8))  u_dut8  (.a(op_a[7:0]),   .b(op_b[7:0]),   .product(p8));

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    // Reference queues: one entry per applied operand pair.
    logic [127:0] q_e64[$];
    logic [63:0]  q_e32[$];
    logic [31:0]  q_e16[$];
    logic [15:0]  q_e8[$];
    string        q_tag[$];

    task automatic check_val(input string req, input int w,
                             input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s width %0d: actual %h expected %h", req, w, act, exp);
        end
    endtask

    task automatic apply(input logic [63:0] x, input logic [63:0] y, input string tag);
        @(posedge clk);
        op_a <= x;
        op_b <= y;
        q_e64.push_back({64'd0, x} * {64'd0, y});
        q_e32.push_back({32'd0, x[31:0]} * {32'd0, y[31:0]});
        q_e16.push_back({16'd0, x[15:0]} * {16'd0, y[15:0]});
        q_e8.push_back({8'd0, x[7:0]} * {8'd0, y[7:0]});
        q_tag.push_back(tag);
    endtask

    // Zero-latency results: compare half a period after each stimulus.
    always @(negedge clk) begin
        if (!rst && q_tag.size() > 0) begin
            string t;
            t = q_tag.pop_front();
            check_val(t, 64, p64,          q_e64.pop_front());
            check_val(t, 32, 128'(p32),    128'(q_e32.pop_front()));
            check_val(t, 16, 128'(p16),    128'(q_e16.pop_front()));
            check_val(t, 8,  128'(p8),     128'(q_e8.pop_front()));
        end
    end

    function automatic logic [63:0] rnd64();
        return {$urandom(), $urandom()};
    endfunction

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk);
        // Reset state: operands idle at zero, product zero (R3).
        check_val("R3 reset", 64, p64, 128'd0);
        check_val("R3 reset", 8, 128'(p8), 128'd0);
        @(posedge clk);
        rst <= 1'b0;

        // R3: zero operand on either side.
        apply(64'd0, 64'd0, "R3");
        apply(64'd0, rnd64(), "R3");
        apply(rnd64(), 64'd0, "R3");

        // R4: unit operand.
        apply(64'd1, rnd64(), "R4");
        apply(rnd64(), 64'd1, "R4");
        apply(64'd1, '1, "R4");

        // R5 and R8: all ones, the largest product and the longest carries.
        apply('1, '1, "R5_R8");
        apply('1, 64'd1, "R5_R8");
        apply({32'd0, 32'hFFFF_FFFF}, {32'd0, 32'hFFFF_FFFF}, "R1_R8");

        // R6: single bits set.
        for (int i = 0; i < 64; i += 5) begin
            apply(64'd1 << i, 64'd1 << (63 - i), "R6");
            apply(64'd1 << i, 64'd1 << i, "R6");
        end
        apply(64'd1 << 63, 64'd1 << 63, "R6");

        // R1, R2: random operands, including small upper halves.
        for (int n = 0; n < 200; n++) begin
            apply(rnd64(), rnd64(), "R1_R2");
        end
        for (int n = 0; n < 40; n++) begin
            apply({32'd0, $urandom()}, {32'd0, $urandom()}, "R1");
        end

        // R7: back-to-back changes alternating extremes every cycle.
        for (int n = 0; n < 30; n++) begin
            apply((n % 2 == 0) ? '1 : rnd64(), (n % 3 == 0) ? 64'd0 : rnd64(), "R7");
        end

        @(posedge clk);
        @(negedge clk);
        @(negedge clk);
        done = 1'b1;
    end

    initial begin
        fork
            begin
                wait (done);
            end
            begin
                repeat (20000) @(posedge clk);
                if (!done) begin
                    checks++;
                    errors++;
                    $display("FAIL R7 watchdog expired");
                end
            end
        join_any
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule